// File: doc/BRIEF.md
# CAN Receive Record Queue

This block holds received CAN frames in a 64-byte circular byte store. Each frame is kept as a record of variable length. A frame arrives on a parallel write port with these fields: extended flag, remote-request flag, 4-bit length code, 29-bit identifier and 8 data bytes. The block packs the frame into a header byte, then the identifier bytes, then the payload. It appends the record one byte per clock, and only when the whole record fits. If it does not fit, the frame is dropped whole and an overrun flag is raised.

The consumer reads the oldest record through a 13-byte window that is addressed relative to the record's start. The window wraps modulo the store size. A release pulse discards the oldest record. The start pointer then moves forward by a length decoded again from the stored header byte.

The queue also keeps a record count and a byte count. While the controller is held in reset mode, no frame is taken in. Leaving reset mode, or a soft clear, empties the queue.

Top module: `can_rx_record_fifo`

## Requirements
- R1: The header byte (record byte 0) carries the extended flag in bit 7, the remote-request flag in bit 6, zeros in bits 5:4, and the 4-bit length code unmodified in bits 3:0.
- R2: An extended record holds ID[28:21] in byte 1, ID[20:13] in byte 2 and ID[12:5] in byte 3. Byte 4 holds ID[4:0] in bits 7:3 and zeros in bits 2:0. Payload starts at byte 5.
- R3: A standard record holds ID[10:3] in byte 1 and ID[2:0] in byte 2 bits 7:5, with zeros below them. Payload starts at byte 3. Payload byte i comes from wr_data[8i+7:8i].
- R4: Record length is 3 bytes, plus 2 when extended, plus min(length code, 8) when not remote-request. A remote-request record stores no payload. After acceptance, busy is high for exactly that many cycles, one byte being written per cycle. The counts change on the cycle the last byte is written. wr_valid is ignored while busy is high.
- R5: If byte_count plus the new record length exceeds 64, nothing is stored. The counts are left unchanged and overrun is set on the next cycle. A clr_overrun pulse clears overrun. If clr_overrun and a new overrun fall in the same cycle, overrun stays set.
- R6: A release pulse with msg_count nonzero decrements msg_count. It moves the start pointer and lowers byte_count by the R4 length decoded from the header byte at the start pointer. With msg_count zero, a release changes nothing.
- R7: has_data goes high when a record is completed and goes low when a release brings msg_count to zero.
- R8: rd_byte combinationally shows the byte at (start + rd_offset) modulo 64, including across the wrap point.
- R9: While reset_mode is high, wr_valid is ignored.
- R10: A soft_clear pulse, or the cycle after reset_mode falls, zeroes the counts and both pointers and aborts any store in progress. soft_clear also clears overrun.
- R11: After rst, busy, has_data, overrun, msg_count, byte_count and rd_byte are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_mode | input | 1 | Controller held in reset mode; blocks reception |
| soft_clear | input | 1 | Empties the queue and clears overrun |
| wr_valid | input | 1 | Offer a frame for storage |
| wr_ext | input | 1 | Frame uses 29-bit identifier |
| wr_rtr | input | 1 | Remote-request frame |
| wr_dlc | input | 4 | Length code |
| wr_id | input | 29 | Identifier (standard uses bits 10:0) |
| wr_data | input | 64 | Payload, byte i in bits 8i+7:8i |
| release_req | input | 1 | Discard oldest record |
| clr_overrun | input | 1 | Clear the overrun flag |
| rd_offset | input | 4 | Byte offset into the oldest record |
| rd_byte | output | 8 | Window byte |
| busy | output | 1 | Record being written |
| has_data | output | 1 | At least one complete record held |
| overrun | output | 1 | A frame was dropped for lack of room |
| msg_count | output | 7 | Complete records held |
| byte_count | output | 7 | Bytes held by complete records |

## Verification
Every registered result is due one clock edge after the stimulus that causes it. A store shows busy one edge after wr_valid, and the counts and has_data move on the edge that writes the record's last byte. rd_byte is combinational, so it follows rd_offset and the start pointer in the same cycle. The bench drives inputs on the falling edge. It advances a behavioural queue model on each rising edge and compares every output a quarter period later, so each comparison sees exactly one edge's worth of change. Hand-computed window bytes are read only while the queue is idle.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;
    localparam int REC_MAX  = 13;
    localparam int LEN_W    = 4;
    localparam int ID_W     = 29;
    localparam int PAY_MAX  = 8;

    typedef logic [7:0] byte_t;
    typedef logic [REC_MAX-1:0][7:0] rec_bytes_t;

    typedef struct packed {
        logic             ext;
        logic             rtr;
        logic [3:0]       dlc;
        logic [ID_W-1:0]  id;
        logic [63:0]      data;
    } can_frame_t;

    function automatic logic [LEN_W-1:0] payload_len(logic rtr, logic [3:0] dlc);
        if (rtr)               return '0;
        else if (dlc > 4'd8)   return 4'd8;
        else                   return dlc;
    endfunction

    function automatic logic [LEN_W-1:0] rec_len(logic ext, logic rtr, logic [3:0] dlc);
        return 4'd3 + (ext ? 4'd2 : 4'd0) + payload_len(rtr, dlc);
    endfunction

    function automatic logic [LEN_W-1:0] hdr_len(byte_t h);
        return rec_len(h[7], h[6], h[3:0]);
    endfunction
endpackage

// File: rtl/can_rxq_packer.sv
module can_rxq_packer
    import can_rxq_pkg::*;
(
    input  can_frame_t              frm,
    output rec_bytes_t              rec,
    output logic [LEN_W-1:0]        len
);
    logic [LEN_W-1:0] npay;

    always_comb begin
        npay   = payload_len(frm.rtr, frm.dlc);
        len    = rec_len(frm.ext, frm.rtr, frm.dlc);
        rec    = '0;
        rec[0] = {frm.ext, frm.rtr, 2'b00, frm.dlc};
        if (frm.ext) begin
            rec[1] = frm.id[28:21];
            rec[2] = frm.id[20:13];
            rec[3] = frm.id[12:5];
            rec[4] = {frm.id[4:0], 3'b000};
            for (int i = 0; i < PAY_MAX; i++)
                if (i < int'(npay)) rec[5+i] = frm.data[8*i +: 8];
        end else begin
            rec[1] = frm.id[10:3];
            rec[2] = {frm.id[2:0], 5'b00000};
            for (int i = 0; i < PAY_MAX; i++)
                if (i < int'(npay)) rec[3+i] = frm.data[8*i +: 8];
        end
    end
endmodule

// File: rtl/can_rxq_ram.sv
module can_rxq_ram
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  byte_t            wdata,
    input  logic [PTR_W-1:0] raddr_a,
    input  logic [PTR_W-1:0] raddr_b,
    output byte_t            rdata_a,
    output byte_t            rdata_b
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)     mem <= '{default: '0};
        else if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/can_rx_record_fifo.sv
module can_rx_record_fifo
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIN   = REC_MAX,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int OFF_W = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_mode,
    input  logic             soft_clear,
    input  logic             wr_valid,
    input  logic             wr_ext,
    input  logic             wr_rtr,
    input  logic [3:0]       wr_dlc,
    input  logic [28:0]      wr_id,
    input  logic [63:0]      wr_data,
    input  logic             release_req,
    input  logic             clr_overrun,
    input  logic [OFF_W-1:0] rd_offset,
    output logic [7:0]       rd_byte,
    output logic             busy,
    output logic             has_data,
    output logic             overrun,
    output logic [CNT_W-1:0] msg_count,
    output logic [CNT_W-1:0] byte_count
);
    // store side state
    logic             busy_q;
    rec_bytes_t       rec_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic [PTR_W-1:0] wptr_q;
    // queue state
    logic [PTR_W-1:0] start_q;
    logic [CNT_W-1:0] msg_q;
    logic [CNT_W-1:0] byte_q;
    logic             has_q;
    logic             ovf_q;
    logic             rm_q;

    can_frame_t       frm_in;
    rec_bytes_t       new_rec;
    logic [LEN_W-1:0] new_len;
    logic [CNT_W:0]   need;
    logic             clear_evt, accept, store_ok, ovf_evt;
    logic             we, last, rel_ok;
    byte_t            hdr_byte, win_byte;
    logic [LEN_W-1:0] rel_len;
    logic [CNT_W-1:0] msg_nxt, byte_nxt;

    assign frm_in = '{ext: wr_ext, rtr: wr_rtr, dlc: wr_dlc, id: wr_id, data: wr_data};

    can_rxq_packer u_pack (
        .frm (frm_in),
        .rec (new_rec),
        .len (new_len)
    );

    assign clear_evt = soft_clear | (rm_q & ~reset_mode);
    assign need      = (CNT_W+1)'(byte_q) + (CNT_W+1)'(new_len);
    assign accept    = wr_valid & ~reset_mode & ~busy_q & ~clear_evt;
    assign store_ok  = accept & (need <= (CNT_W+1)'(DEPTH));
    assign ovf_evt   = accept & ~(need <= (CNT_W+1)'(DEPTH));
    assign we        = busy_q & ~clear_evt;
    assign last      = we & (idx_q == len_q - 1'b1);
    assign rel_ok    = release_req & (msg_q != '0) & ~clear_evt;
    assign rel_len   = hdr_len(hdr_byte);

    can_rxq_ram #(.DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .waddr   (wptr_q),
        .wdata   (rec_q[idx_q]),
        .raddr_a (start_q + PTR_W'(rd_offset)),
        .raddr_b (start_q),
        .rdata_a (win_byte),
        .rdata_b (hdr_byte)
    );

    always_comb begin
        msg_nxt  = msg_q + (last ? CNT_W'(1) : '0) - (rel_ok ? CNT_W'(1) : '0);
        byte_nxt = byte_q + (last ? CNT_W'(len_q) : '0) - (rel_ok ? CNT_W'(rel_len) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            rec_q   <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            wptr_q  <= '0;
            start_q <= '0;
            msg_q   <= '0;
            byte_q  <= '0;
            has_q   <= 1'b0;
            ovf_q   <= 1'b0;
            rm_q    <= 1'b0;
        end else begin
            rm_q <= reset_mode;
            if (clear_evt) begin
                busy_q  <= 1'b0;
                idx_q   <= '0;
                wptr_q  <= '0;
                start_q <= '0;
                msg_q   <= '0;
                byte_q  <= '0;
                has_q   <= 1'b0;
                if (soft_clear) ovf_q <= 1'b0;
                else if (clr_overrun) ovf_q <= 1'b0;
            end else begin
                if (store_ok) begin
                    busy_q <= 1'b1;
                    rec_q  <= new_rec;
                    len_q  <= new_len;
                    idx_q  <= '0;
                end else if (last) begin
                    busy_q <= 1'b0;
                end
                if (we) begin
                    wptr_q <= wptr_q + 1'b1;
                    idx_q  <= idx_q + 1'b1;
                end
                if (rel_ok) start_q <= start_q + PTR_W'(rel_len);
                msg_q  <= msg_nxt;
                byte_q <= byte_nxt;
                has_q  <= (msg_nxt != '0);
                if (ovf_evt)          ovf_q <= 1'b1;
                else if (clr_overrun) ovf_q <= 1'b0;
            end
        end
    end

    assign rd_byte    = win_byte;
    assign busy       = busy_q;
    assign has_data   = has_q;
    assign overrun    = ovf_q;
    assign msg_count  = msg_q;
    assign byte_count = byte_q;

    // store index never runs past the record being written
    assert_idx_in_rec_R4: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q < len_q))
        else $error("store index past record length");

    // committed bytes never exceed the store
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        byte_q <= CNT_W'(DEPTH))
        else $error("byte count exceeds depth");

    // overrun only rises after a frame was offered
    assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(wr_valid))
        else $error("overrun without offered frame");

    // release on an empty queue leaves the start pointer alone
    assert_empty_release_R6: assert property (@(posedge clk) disable iff (rst)
        (release_req && msg_q == '0 && !clear_evt) |=> $stable(start_q))
        else $error("empty release moved start");

    // no records means no bytes held
    assert_empty_bytes_R7: assert property (@(posedge clk) disable iff (rst)
        (msg_q == '0) |-> (byte_q == '0))
        else $error("bytes held with zero records");

    // reset mode refuses reception
    assert_refuse_R9: assert property (@(posedge clk) disable iff (rst)
        (reset_mode && !busy_q) |=> !busy_q)
        else $error("store started in reset mode");
endmodule

// File: tb/sim_can_rx_record_fifo.sv
module sim_can_rx_record_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_mode = 1'b1, soft_clear = 1'b0;
    logic        wr_valid = 1'b0, wr_ext = 1'b0, wr_rtr = 1'b0;
    logic [3:0]  wr_dlc = '0;
    logic [28:0] wr_id = '0;
    logic [63:0] wr_data = '0;
    logic        release_req = 1'b0, clr_overrun = 1'b0;
    logic [3:0]  rd_offset = '0;
    logic [7:0]  rd_byte;
    logic        busy, has_data, overrun;
    logic [6:0]  msg_count, byte_count;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    can_rx_record_fifo u0 (
        .clk, .rst, .reset_mode, .soft_clear, .wr_valid, .wr_ext, .wr_rtr,
        .wr_dlc, .wr_id, .wr_data, .release_req, .clr_overrun, .rd_offset,
        .rd_byte, .busy, .has_data, .overrun, .msg_count, .byte_count
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_q [$];
    int  m_start = 0, m_wptr = 0, m_bytes = 0, m_msgs = 0, m_pend = 0;
    bit  m_busy = 0, m_ovf = 0, m_prev_rm = 0;

    function automatic int m_len(logic [7:0] h);
        int n;
        n = h[6] ? 0 : ((h[3:0] > 8) ? 8 : int'(h[3:0]));
        return 3 + (h[7] ? 2 : 0) + n;
    endfunction

    task automatic m_build();
        int n;
        m_q.delete();
        m_q.push_back({wr_ext, wr_rtr, 2'b00, wr_dlc});
        if (wr_ext) begin
            m_q.push_back(8'((wr_id >> 21) & 29'hff));
            m_q.push_back(8'((wr_id >> 13) & 29'hff));
            m_q.push_back(8'((wr_id >> 5) & 29'hff));
            m_q.push_back(8'((wr_id & 29'h1f) << 3));
        end else begin
            m_q.push_back(8'((wr_id >> 3) & 29'hff));
            m_q.push_back(8'((wr_id & 29'h7) << 5));
        end
        n = wr_rtr ? 0 : ((wr_dlc > 8) ? 8 : int'(wr_dlc));
        for (int i = 0; i < n; i++) m_q.push_back(wr_data[8*i +: 8]);
    endtask

    task automatic m_step();
        int add, inc, rl;
        bit ovf_set;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
            m_start = 0; m_wptr = 0; m_bytes = 0; m_msgs = 0;
            m_busy = 0; m_ovf = 0; m_prev_rm = 0; m_q.delete();
            return;
        end
        if (soft_clear || (m_prev_rm && !reset_mode)) begin
            m_start = 0; m_wptr = 0; m_bytes = 0; m_msgs = 0;
            m_busy = 0; m_q.delete();
            if (soft_clear || clr_overrun) m_ovf = 0;
            m_prev_rm = reset_mode;
            return;
        end
        add = 0; inc = 0; ovf_set = 0; rl = 0;
        if (release_req && m_msgs != 0) rl = m_len(m_mem[m_start]);
        if (m_busy) begin
            m_mem[m_wptr] = m_q.pop_front();
            m_wptr = (m_wptr + 1) % DEPTH;
            if (m_q.size() == 0) begin
                m_busy = 0; inc = 1; add = m_pend;
            end
        end else if (wr_valid && !reset_mode) begin
            m_build();
            if (m_bytes + m_q.size() > DEPTH) begin
                ovf_set = 1; m_q.delete();
            end else begin
                m_busy = 1; m_pend = m_q.size();
            end
        end
        if (rl != 0) begin
            m_start = (m_start + rl) % DEPTH;
            m_bytes -= rl;
            m_msgs  -= 1;
        end
        m_bytes += add;
        m_msgs  += inc;
        if (ovf_set) m_ovf = 1;
        else if (clr_overrun) m_ovf = 0;
        m_prev_rm = reset_mode;
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        m_step();
        cycles++;
        #(CLK_PERIOD/4);
        if (!rst) begin
            chk(busy == m_busy, "R4", "busy", int'(busy), int'(m_busy));
            chk(int'(msg_count) == m_msgs, "R6", "msg_count", int'(msg_count), m_msgs);
            chk(int'(byte_count) == m_bytes, "R6", "byte_count", int'(byte_count), m_bytes);
            chk(has_data == (m_msgs != 0), "R7", "has_data", int'(has_data), int'(m_msgs != 0));
            chk(overrun == m_ovf, "R5", "overrun", int'(overrun), int'(m_ovf));
            chk(rd_byte == m_mem[(m_start + int'(rd_offset)) % DEPTH], "R8", "rd_byte",
                int'(rd_byte), int'(m_mem[(m_start + int'(rd_offset)) % DEPTH]));
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic offer(bit ext, bit rtr, logic [3:0] dlc, logic [28:0] id, logic [63:0] d);
        @(negedge clk);
        wr_valid = 1; wr_ext = ext; wr_rtr = rtr; wr_dlc = dlc; wr_id = id; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic idle();
        do @(negedge clk); while (busy);
        @(negedge clk);
    endtask

    task automatic send(bit ext, bit rtr, logic [3:0] dlc, logic [28:0] id, logic [63:0] d);
        offer(ext, rtr, dlc, id, d);
        idle();
    endtask

    task automatic pulse_release();
        @(negedge clk); release_req = 1;
        @(negedge clk); release_req = 0;
    endtask

    task automatic hand(int off, logic [7:0] exp, string tag);
        @(negedge clk); rd_offset = 4'(off);
        #1;
        chk(rd_byte == exp, tag, "window byte", int'(rd_byte), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk(!busy && !has_data && !overrun && msg_count == 0 && byte_count == 0 && rd_byte == 0,
            "R11", "reset state", {busy, has_data, overrun}, 0);
        // R9: refused in reset mode
        offer(0, 0, 4'd2, 29'h55, 64'h1);
        @(negedge clk);
        chk(msg_count == 0 && !busy, "R9", "reset mode refusal", int'(msg_count), 0);
        // R10: leave reset mode
        reset_mode = 0;
        @(negedge clk);
        // R1, R3: standard record layout
        send(0, 0, 4'd2, 29'h123, 64'hBBAA);
        hand(0, 8'h02, "R1"); hand(1, 8'h24, "R3"); hand(2, 8'h60, "R3");
        hand(3, 8'hAA, "R3"); hand(4, 8'hBB, "R3");
        send(1, 0, 4'd3, 29'h1ABCDEF5, 64'h332211);
        send(0, 1, 4'd5, 29'h7FF, 64'hFFFF);         // R4: remote request, no payload
        send(1, 1, 4'd15, 29'h0, 64'h0);
        send(0, 0, 4'd12, 29'h001, 64'h0807060504030201); // R4: length clamp
        send(0, 0, 4'd0, 29'h400, 64'h0);
        pulse_release();
        // R2: extended record layout
        hand(0, 8'h83, "R1"); hand(1, 8'hD5, "R2"); hand(2, 8'hE6, "R2");
        hand(3, 8'hF7, "R2"); hand(4, 8'hA8, "R2"); hand(5, 8'h11, "R2"); hand(7, 8'h33, "R2");
        for (int i = 0; i < 5; i++) pulse_release();
        pulse_release();                             // R6: release when empty
        @(negedge clk);
        chk(msg_count == 0 && !has_data, "R6", "empty release", int'(msg_count), 0);
        // R5: fill until a frame does not fit
        for (int i = 0; i < 5; i++) send(0, 0, 4'd8, 29'(i), {8{8'(8'h10 + i)}});
        send(0, 0, 4'd8, 29'h3, 64'h0);
        chk(overrun && msg_count == 5, "R5", "overrun", int'(overrun), 1);
        @(negedge clk); clr_overrun = 1; @(negedge clk); clr_overrun = 0;
        // R8: wrap the window across the end of the store
        for (int i = 0; i < 3; i++) pulse_release();
        for (int i = 0; i < 3; i++) send(1, 0, 4'd8, 29'(i * 77), {8{8'(8'hC0 + i)}});
        for (int k = 0; k < 13; k++) begin
            @(negedge clk); rd_offset = 4'(k);
        end
        // R4: a second offer while busy is ignored, release during a store
        pulse_release();
        offer(0, 0, 4'd1, 29'h10, 64'h5A);
        @(negedge clk); wr_valid = 1; release_req = 1;
        @(negedge clk); wr_valid = 0; release_req = 0;
        idle();
        // R10: soft clear with data present
        @(negedge clk); soft_clear = 1; @(negedge clk); soft_clear = 0;
        @(negedge clk);
        chk(msg_count == 0 && byte_count == 0, "R10", "soft clear", int'(msg_count), 0);
        send(0, 0, 4'd1, 29'h2, 64'h77);
        // R10: re-enter and leave reset mode with a store in progress
        offer(1, 0, 4'd8, 29'h5, 64'h1);
        reset_mode = 1;
        @(negedge clk); reset_mode = 0;
        idle();
        chk(msg_count == 0 && !busy, "R10", "leave reset mode", int'(msg_count), 0);
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule